// File: doc/BRIEF.md
# Pipelined Grouped XOR Combiner for Entropy Streams

This block folds a wide vector of raw entropy bits, one bit per free-running source, into a single combined bit on every clock. The sources are sampled on a shared clock. The vector is cut into groups whose width matches the input count of one lookup table. Each group is reduced by XOR and the result is registered.

The registered group results form a narrower vector. That vector is grouped and reduced again, level after level, until one bit is left. Because a register follows each level, the logic depth of any path is a single group reduction. The price is a latency equal to the number of levels.

A valid flag stays low after reset. It rises once the pipeline holds results that were computed entirely from sampled input vectors.

Top module: `entropy_xor_combiner`

## Requirements
- R1: With SRC_COUNT inputs (SRC_COUNT > 1) and groups of at most GROUP_WIDTH bits (GROUP_WIDTH >= 2), the tree has L levels, where L is the smallest integer with GROUP_WIDTH^L >= SRC_COUNT.
- R2: While reset is held, and on the edges that follow until the pipeline has filled, mix_valid and mix_bit are both 0.
- R3: mix_valid rises on exactly the L-th rising edge at which rst is sampled low, and it then stays high until the next reset.
- R4: While mix_valid is high, mix_bit equals the XOR of all SRC_COUNT bits of raw_bits as sampled L rising edges earlier.
- R5: A new combined bit is produced on every clock, so consecutive input vectors give consecutive results with no gaps.
- R6: A group left short at the end of a level is reduced over only the bits it holds. Flipping any single input bit position, including positions that fall in a short group, flips mix_bit.
- R7: An all-ones input vector gives mix_bit = SRC_COUNT mod 2, and an all-zeros vector gives 0.
- R8: When SRC_COUNT <= GROUP_WIDTH the latency is 1 cycle. With SRC_COUNT = 216 and GROUP_WIDTH = 6 it is 3 cycles.
- R9: Asserting rst in the middle of a stream clears mix_valid and mix_bit on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_bits | input | SRC_COUNT | One sampled bit from each entropy source |
| mix_bit | output | 1 | Combined XOR of a whole input vector |
| mix_valid | output | 1 | High once the pipeline has filled |

## Verification
The bench runs the same stream through six configurations. These cover a single level, trees with a full final group and with a short final group, a small group width that gives three levels, and the 216-input three-level case.

Walking one-hot vectors prove that every bit position reaches the output exactly once; a position that was dropped or counted twice would show here. All-zeros and all-ones vectors separate odd source counts from even ones. Random vectors streamed back to back expose any latency that is off by one cycle, and a reset pulse in the middle of a stream shows that the fill state restarts.

// File: rtl/entropy_xor_pkg.sv
package entropy_xor_pkg;

    // Ceiling of a / b for positive operands.
    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    // Number of register levels needed to reduce k bits to one (R1).
    function automatic int tree_levels(input int k, input int g);
        int w;
        int n;
        w = k;
        n = 0;
        if (g < 2) return 0;
        while (w > 1) begin
            w = ceil_div(w, g);
            n++;
        end
        return n;
    endfunction

    // Width of the vector entering level lvl (lvl = 0 is the raw input).
    function automatic int level_width(input int k, input int g, input int lvl);
        int w;
        w = k;
        for (int i = 0; i < lvl; i++) begin
            w = ceil_div(w, g);
        end
        return w;
    endfunction

endpackage

// File: rtl/xor_group_cell.sv
module xor_group_cell #(
    parameter int SPAN = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [SPAN-1:0] grp_in,
    output logic            grp_q
);
    always_ff @(posedge clk) begin
        if (rst) grp_q <= 1'b0;
        else     grp_q <= ^grp_in;
    end
endmodule

// File: rtl/xor_tree_level.sv
module xor_tree_level #(
    parameter int W_IN        = 25,
    parameter int GROUP_WIDTH = 6
) (
    input  logic                                                    clk,
    input  logic                                                    rst,
    input  logic [W_IN-1:0]                                         lvl_in,
    output logic [entropy_xor_pkg::ceil_div(W_IN, GROUP_WIDTH)-1:0] lvl_out
);
    import entropy_xor_pkg::*;

    localparam int W_OUT = ceil_div(W_IN, GROUP_WIDTH);

    for (genvar j = 0; j < W_OUT; j++) begin : group_g
        localparam int LO   = j * GROUP_WIDTH;
        // The final group may hold fewer bits than GROUP_WIDTH (R6).
        localparam int SPAN = ((W_IN - LO) < GROUP_WIDTH) ? (W_IN - LO) : GROUP_WIDTH;
        xor_group_cell #(.SPAN(SPAN)) u_cell (
            .clk    (clk),
            .rst    (rst),
            .grp_in (lvl_in[LO +: SPAN]),
            .grp_q  (lvl_out[j])
        );
    end
endmodule

// File: rtl/fill_tracker.sv
module fill_tracker #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    output logic full
);
    logic [DEPTH-1:0] fill_sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_sr <= '0;
        end else begin
            fill_sr[0] <= 1'b1;
            for (int i = 1; i < DEPTH; i++) begin
                fill_sr[i] <= fill_sr[i-1];
            end
        end
    end

    assign full = fill_sr[DEPTH-1];
endmodule

// File: rtl/entropy_xor_combiner.sv
module entropy_xor_combiner #(
    parameter int SRC_COUNT   = 25,
    parameter int GROUP_WIDTH = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SRC_COUNT-1:0] raw_bits,
    output logic                 mix_bit,
    output logic                 mix_valid
);
    import entropy_xor_pkg::*;

    localparam int LEVELS = tree_levels(SRC_COUNT, GROUP_WIDTH);

    for (genvar l = 0; l < LEVELS; l++) begin : stage_g
        localparam int WI = level_width(SRC_COUNT, GROUP_WIDTH, l);
        localparam int WO = level_width(SRC_COUNT, GROUP_WIDTH, l + 1);
        logic [WI-1:0] din;
        logic [WO-1:0] dout;

        if (l == 0) begin : g_first
            assign din = raw_bits;
        end else begin : g_next
            assign din = stage_g[l-1].dout;
        end

        xor_tree_level #(.W_IN(WI), .GROUP_WIDTH(GROUP_WIDTH)) u_level (
            .clk     (clk),
            .rst     (rst),
            .lvl_in  (din),
            .lvl_out (dout)
        );
    end

    assign mix_bit = stage_g[LEVELS-1].dout[0];

    fill_tracker #(.DEPTH(LEVELS)) u_fill (
        .clk  (clk),
        .rst  (rst),
        .full (mix_valid)
    );
endmodule

// File: rtl/entropy_xor_combiner_chk.sv
module entropy_xor_combiner_chk #(
    parameter int SRC_COUNT   = 25,
    parameter int GROUP_WIDTH = 6
) (
    input logic                 clk,
    input logic                 rst,
    input logic [SRC_COUNT-1:0] raw_bits,
    input logic                 mix_bit,
    input logic                 mix_valid
);
    import entropy_xor_pkg::*;

    localparam int LEVELS = tree_levels(SRC_COUNT, GROUP_WIDTH);
    localparam int CW     = $clog2(LEVELS + 2);

    logic [CW-1:0]     since_rst;
    logic [LEVELS-1:0] par_pipe;

    always_ff @(posedge clk) begin
        if (rst)                       since_rst <= '0;
        else if (since_rst < CW'(LEVELS)) since_rst <= since_rst + 1'b1;
    end

    always_ff @(posedge clk) begin
        par_pipe[0] <= ^raw_bits;
        for (int i = 1; i < LEVELS; i++) par_pipe[i] <= par_pipe[i-1];
    end

    // R2: outputs quiet until the pipeline has filled
    p_quiet_fill_r2: assert property (@(posedge clk) disable iff (rst)
        (since_rst < CW'(LEVELS)) |-> (!mix_valid && !mix_bit));

    // R3, R8: valid rises exactly after LEVELS edges out of reset
    p_valid_latency_r3: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= CW'(LEVELS)) |-> mix_valid);

    // R3: valid stays high until reset
    p_valid_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        mix_valid |=> mix_valid);

    // R4, R5: combined bit matches the input parity LEVELS edges earlier
    p_parity_match_r4: assert property (@(posedge clk) disable iff (rst)
        mix_valid |-> (mix_bit == par_pipe[LEVELS-1]));
endmodule

bind entropy_xor_combiner entropy_xor_combiner_chk #(
    .SRC_COUNT   (SRC_COUNT),
    .GROUP_WIDTH (GROUP_WIDTH)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .raw_bits  (raw_bits),
    .mix_bit   (mix_bit),
    .mix_valid (mix_valid)
);

// File: tb/entropy_xor_combiner_test.sv
`timescale 1ns/100ps

module combiner_harness #(
    parameter int    SRC_COUNT   = 25,
    parameter int    GROUP_WIDTH = 6,
    parameter int    EXP_LEVELS  = 2,
    parameter string TAG         = "cfg"
) (
    input  logic clk,
    output logic done,
    output int   checks,
    output int   fails
);
    logic                 rst;
    logic [SRC_COUNT-1:0] raw_bits;
    logic                 mix_bit;
    logic                 mix_valid;
    bit                   hist [0:511];

    entropy_xor_combiner #(.SRC_COUNT(SRC_COUNT), .GROUP_WIDTH(GROUP_WIDTH)) uut (
        .clk       (clk),
        .rst       (rst),
        .raw_bits  (raw_bits),
        .mix_bit   (mix_bit),
        .mix_valid (mix_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", TAG, req, act, exp);
        end
    endtask

    task automatic drive_vec(input int m);
        if (m < SRC_COUNT) begin
            raw_bits = '0;
            raw_bits[m] = 1'b1;
        end else if (m == SRC_COUNT) begin
            raw_bits = '0;
        end else if (m == SRC_COUNT + 1) begin
            raw_bits = '1;
        end else begin
            for (int i = 0; i < SRC_COUNT; i++) raw_bits[i] = 1'($urandom % 2);
        end
    endtask

    task automatic run_stream(input int n);
        for (int m = 0; m < n; m++) begin
            if (m == 0) rst = 1'b0;
            check(mix_valid == (m >= EXP_LEVELS), "R3 R8 valid latency",
                  int'(mix_valid), int'(m >= EXP_LEVELS));
            if (m >= EXP_LEVELS) begin
                int src;
                src = m - EXP_LEVELS;
                if (src < SRC_COUNT)
                    check(mix_bit == hist[src], "R6 single bit reaches output",
                          int'(mix_bit), int'(hist[src]));
                else if (src == SRC_COUNT + 1)
                    check(mix_bit == hist[src], "R7 all ones parity",
                          int'(mix_bit), SRC_COUNT % 2);
                else
                    check(mix_bit == hist[src], "R4 R5 streamed parity",
                          int'(mix_bit), int'(hist[src]));
            end
            drive_vec(m);
            hist[m] = ^raw_bits;
            @(negedge clk);
        end
    endtask

    initial begin
        done     = 1'b0;
        checks   = 0;
        fails    = 0;
        rst      = 1'b1;
        raw_bits = '0;
        repeat (3) @(negedge clk);
        check(!mix_valid && !mix_bit, "R2 reset state", int'({mix_valid, mix_bit}), 0);
        run_stream(SRC_COUNT + 2 + 120);
        rst = 1'b1;
        drive_vec(SRC_COUNT + 5);
        @(negedge clk);
        check(!mix_valid && !mix_bit, "R9 reset mid stream", int'({mix_valid, mix_bit}), 0);
        run_stream(60);
        done = 1'b1;
    end
endmodule

module entropy_xor_combiner_test;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic d0, d1, d2, d3, d4, d5;
    int   c0, c1, c2, c3, c4, c5;
    int   f0, f1, f2, f3, f4, f5;
    bit   timed_out = 1'b0;

    combiner_harness #(.SRC_COUNT(25),  .GROUP_WIDTH(6), .EXP_LEVELS(2), .TAG("k25g6"))
        h0 (.clk(clk), .done(d0), .checks(c0), .fails(f0));
    combiner_harness #(.SRC_COUNT(7),   .GROUP_WIDTH(6), .EXP_LEVELS(2), .TAG("k7g6"))
        h1 (.clk(clk), .done(d1), .checks(c1), .fails(f1));
    combiner_harness #(.SRC_COUNT(6),   .GROUP_WIDTH(6), .EXP_LEVELS(1), .TAG("k6g6"))
        h2 (.clk(clk), .done(d2), .checks(c2), .fails(f2));
    combiner_harness #(.SRC_COUNT(216), .GROUP_WIDTH(6), .EXP_LEVELS(3), .TAG("k216g6"))
        h3 (.clk(clk), .done(d3), .checks(c3), .fails(f3));
    combiner_harness #(.SRC_COUNT(10),  .GROUP_WIDTH(3), .EXP_LEVELS(3), .TAG("k10g3"))
        h4 (.clk(clk), .done(d4), .checks(c4), .fails(f4));
    combiner_harness #(.SRC_COUNT(2),   .GROUP_WIDTH(6), .EXP_LEVELS(1), .TAG("k2g6"))
        h5 (.clk(clk), .done(d5), .checks(c5), .fails(f5));

    initial begin
        int total_checks;
        int total_fails;
        fork
            begin
                wait (d0 && d1 && d2 && d3 && d4 && d5);
            end
            begin
                repeat (100000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        total_checks = c0 + c1 + c2 + c3 + c4 + c5;
        total_fails  = f0 + f1 + f2 + f3 + f4 + f5;
        if (timed_out) begin
            total_checks++;
            total_fails++;
            $display("FAIL watchdog R4: actual=timeout expected=completion");
        end
        $display("TB_RESULT checks=%0d failures=%0d", total_checks, total_fails);
        $finish;
    end
endmodule